// File: doc/BRIEF.md
# PMIC Register Access Bridge

This block sits on the processor side of a link to a companion power-management chip. Software posts register writes into a small command queue, and the engine sends them to the slave registers one at a time. Software starts a read by presenting the slave offset on the read-command port. No separate start strobe is needed. A busy flag stays high until the answer arrives. The answer word holds the 16-bit register value together with an echo of the address, so software can confirm that the data belongs to the register it asked for.

Offsets are decoded in one of three selectable address modes: 10, 12 or 15 bits, with the two lowest bits always zero. The wide modes split the offset so that its two top bits choose one of three slaves. An access outside the active window raises an error and starts nothing. The serial link itself is replaced by a modelled slave register file. That model answers every transaction after a fixed number of cycles.

The engine is a three-state machine. The states are `ST_IDLE`, `ST_WRITE` and `ST_READ`, and there are five transitions:
- IDLE->READ fires when a read is pending and no earlier write is still queued.
- IDLE->WRITE pops the oldest queued write.
- IDLE->IDLE applies when there is nothing to do.
- WRITE->IDLE and READ->IDLE fire on the last transfer cycle.

Top module: `pmic_bridge`

## Requirements
- R1: After reset, `fifo_empty`=1, `fifo_full`=0, `rd_busy`=0, `rd_word`=0 and `err`=0. Every slave register reads 0.
- R2: A valid write request is queued at the clock edge if the queue is not full. `fifo_full` is high when FIFO_DEPTH entries are held, and `fifo_empty` is high when none are held.
- R3: A valid write presented while `fifo_full` is high is dropped. A later read of that register still returns its old value.
- R4: Queued writes go out in arrival order. Each write transfer lasts XFER_CYC cycles. The next queued entry is popped in the cycle after the previous transfer completes.
- R5: A read request with `rd_busy` low and a valid offset sets `rd_busy` at the next edge. A read request while `rd_busy` is high is ignored.
- R6: A read starts only after every write queued before it has completed, including a write presented in the same cycle. The read then lasts XFER_CYC cycles. `rd_busy` falls and `rd_word` updates on the same edge.
- R7: `rd_word` has the register value in [15:0], the address echo in [30:16] and 0 in bit 31. The echo is offset[14:0] when `rev_new`=0 and offset[16:2] when `rev_new`=1.
- R8: Address modes by `mode_sel`:
  - 0 (10-bit): the window is below 0x1000 and there is one slave, slave 0.
  - 1 (12-bit): the window is below 0x4000 and the slave is offset[13:12].
  - 2 (15-bit): the window is below 0x20000 and the slave is offset[16:15].
  - 3: reserved, and every access is rejected.
- R9: A write or read with an offset outside the window, or one that selects slave 3, drives `err` high for exactly the next cycle. It queues nothing and does not start a read.
- R10: Within a slave, offset[5:2] selects one of 16 registers. The three slaves hold independent registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mode_sel | input | 2 | Address mode (0: 10-bit, 1: 12-bit, 2: 15-bit, 3: reserved) |
| rev_new | input | 1 | Echo format select |
| wr_req | input | 1 | Write request, one cycle |
| wr_off | input | 18 | Slave offset for the write |
| wr_data | input | 16 | Write value |
| rd_req | input | 1 | Read command, one cycle |
| rd_off | input | 18 | Slave offset for the read |
| fifo_full | output | 1 | Write queue full |
| fifo_empty | output | 1 | Write queue empty |
| rd_busy | output | 1 | Read in flight |
| rd_word | output | 32 | Echo and data of the last completed read |
| err | output | 1 | Rejected access, one-cycle pulse |

## Verification
The assertions assume that `mode_sel` and `rev_new` stay constant while a write is queued, a transfer is under way or a read is pending. Changing either of them mid-flight would re-decode an access that was already accepted. The stimulus respects this: it changes mode or echo format only after a settling interval long enough to drain a full queue and finish a read. Within a mode, the stimulus issues requests back to back. This covers queue saturation, a read that shares its cycle with a write, and a second read command while one is still in flight.

// File: rtl/pmb_pkg.sv
package pmb_pkg;
    localparam int OFF_W  = 18;
    localparam int DATA_W = 16;
    localparam int ECHO_W = 15;
    localparam int SID_W  = 2;

    typedef enum logic [1:0] {
        MODE_A10  = 2'd0,
        MODE_A12  = 2'd1,
        MODE_A15  = 2'd2,
        MODE_RSVD = 2'd3
    } amode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_READ  = 2'd2
    } eng_st_e;
endpackage

// File: rtl/pmb_addr_check.sv
module pmb_addr_check
    import pmb_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic [OFF_W-1:0] off,
    input  logic [1:0]       mode,
    output logic             ok,
    output logic [SID_W-1:0] sid,
    output logic [IDX_W-1:0] idx
);
    assign idx = off[IDX_W+1:2];

    always_comb begin
        ok  = 1'b0;
        sid = '0;
        unique case (amode_e'(mode))
            MODE_A10: begin
                sid = '0;
                ok  = off < OFF_W'(18'h01000);
            end
            MODE_A12: begin
                sid = off[13:12];
                ok  = (off < OFF_W'(18'h04000)) && (off[13:12] != 2'd3);
            end
            MODE_A15: begin
                sid = off[16:15];
                ok  = (off < OFF_W'(18'h20000)) && (off[16:15] != 2'd3);
            end
            MODE_RSVD: begin
                sid = '0;
                ok  = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/pmb_wfifo.sv
module pmb_wfifo #(
    parameter int W     = 22,
    parameter int DEPTH = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           push,
    input  logic                           pop,
    input  logic [W-1:0]                   din,
    output logic [W-1:0]                   dout,
    output logic                           full,
    output logic                           empty,
    output logic [$clog2(DEPTH+1)-1:0]     count
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH+1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wp, rp;

    assign full  = count == CNT_W'(DEPTH);
    assign empty = count == '0;
    assign dout  = mem[rp];

    always_ff @(posedge clk) begin
        if (push) mem[wp] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (push) wp <= (wp == PTR_W'(DEPTH-1)) ? '0 : wp + 1'b1;
            if (pop)  rp <= (rp == PTR_W'(DEPTH-1)) ? '0 : rp + 1'b1;
            unique case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R2: the queue never takes an entry beyond its depth, nor gives one it lacks
    always_comb begin
        if (rst_n) begin
            p_no_overflow_r2:  assert (!(push && full));
            p_no_underflow_r2: assert (!(pop && empty));
        end
    end
endmodule

// File: rtl/pmb_slave_model.sv
module pmb_slave_model
    import pmb_pkg::*;
#(
    parameter int NSLV  = 3,
    parameter int IDX_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [SID_W-1:0]  wsid,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [SID_W-1:0]  rsid,
    input  logic [IDX_W-1:0]  ridx,
    output logic [DATA_W-1:0] rdata
);
    localparam int REGS = 1 << IDX_W;

    logic [NSLV-1:0]   we_vec;
    logic [DATA_W-1:0] slv_rd [NSLV];

    for (genvar g = 0; g < NSLV; g++) begin : g_bank
        logic [DATA_W-1:0] bank [REGS];
        assign we_vec[g] = we && (wsid == SID_W'(g));
        assign slv_rd[g] = bank[ridx];
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int i = 0; i < REGS; i++) bank[i] <= '0;
            end else if (we_vec[g]) begin
                bank[widx] <= wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int s = 0; s < NSLV; s++)
            if (rsid == SID_W'(s)) rdata = slv_rd[s];
    end

    // R10: one completed write lands in at most one slave
    p_one_bank_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(we_vec));
endmodule

// File: rtl/pmic_bridge.sv
module pmic_bridge
    import pmb_pkg::*;
#(
    parameter int FIFO_DEPTH = 4,
    parameter int XFER_CYC   = 4,
    parameter int REG_IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_sel,
    input  logic              rev_new,
    input  logic              wr_req,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_req,
    input  logic [OFF_W-1:0]  rd_off,
    output logic              fifo_full,
    output logic              fifo_empty,
    output logic              rd_busy,
    output logic [31:0]       rd_word,
    output logic              err
);
    localparam int NSLV   = 3;
    localparam int ENT_W  = SID_W + REG_IDX_W + DATA_W;
    localparam int FCNT_W = $clog2(FIFO_DEPTH+1);
    localparam int XCNT_W = $clog2(XFER_CYC+1);

    eng_st_e state, state_nx;

    logic                 wr_ok, rd_ok;
    logic [SID_W-1:0]     wr_sid, rd_sid;
    logic [REG_IDX_W-1:0] wr_idx, rd_idx;
    logic                 push, pop, rd_acc, start_rd, xfer_last;
    logic [ENT_W-1:0]     fifo_dout, cur;
    logic [FCNT_W-1:0]    fcount, ahead;
    logic [XCNT_W-1:0]    cnt;
    logic [ECHO_W-1:0]    echo;
    logic [SID_W-1:0]     rsid_q;
    logic [REG_IDX_W-1:0] ridx_q;
    logic [DATA_W-1:0]    slv_rdata;
    logic                 slv_we;

    pmb_addr_check #(.IDX_W(REG_IDX_W)) u_wchk (
        .off(wr_off), .mode(mode_sel), .ok(wr_ok), .sid(wr_sid), .idx(wr_idx));
    pmb_addr_check #(.IDX_W(REG_IDX_W)) u_rchk (
        .off(rd_off), .mode(mode_sel), .ok(rd_ok), .sid(rd_sid), .idx(rd_idx));

    assign push      = wr_req && wr_ok && !fifo_full;
    assign rd_acc    = rd_req && !rd_busy && rd_ok;
    assign xfer_last = cnt == XCNT_W'(XFER_CYC-1);
    assign start_rd  = (state == ST_IDLE) && rd_busy && (ahead == '0);
    assign pop       = (state == ST_IDLE) && !start_rd && !fifo_empty;
    assign slv_we    = (state == ST_WRITE) && xfer_last;

    pmb_wfifo #(.W(ENT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
        .din({wr_sid, wr_idx, wr_data}), .dout(fifo_dout),
        .full(fifo_full), .empty(fifo_empty), .count(fcount));

    pmb_slave_model #(.NSLV(NSLV), .IDX_W(REG_IDX_W)) u_slv (
        .clk(clk), .rst_n(rst_n), .we(slv_we),
        .wsid(cur[ENT_W-1 -: SID_W]), .widx(cur[DATA_W +: REG_IDX_W]),
        .wdata(cur[DATA_W-1:0]), .rsid(rsid_q), .ridx(ridx_q), .rdata(slv_rdata));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (start_rd) state_nx = ST_READ;
                else if (pop) state_nx = ST_WRITE;
            end
            ST_WRITE: if (xfer_last) state_nx = ST_IDLE;
            ST_READ:  if (xfer_last) state_nx = ST_IDLE;
        endcase
    end

    // outputs and transfer datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            cur     <= '0;
            ahead   <= '0;
            rd_busy <= 1'b0;
            echo    <= '0;
            rsid_q  <= '0;
            ridx_q  <= '0;
            rd_word <= '0;
            err     <= 1'b0;
        end else begin
            err <= (wr_req && !wr_ok) || (rd_req && !rd_busy && !rd_ok);
            if (state == ST_IDLE) cnt <= '0;
            else if (!xfer_last)  cnt <= cnt + 1'b1;
            if (pop) cur <= fifo_dout;
            if (rd_acc) begin
                rd_busy <= 1'b1;
                ahead   <= fcount + FCNT_W'(push) - FCNT_W'(pop);
                echo    <= rev_new ? rd_off[16:2] : rd_off[14:0];
                rsid_q  <= rd_sid;
                ridx_q  <= rd_idx;
            end else if (pop && rd_busy) begin
                ahead <= ahead - 1'b1;
            end
            if ((state == ST_READ) && xfer_last) begin
                rd_busy <= 1'b0;
                rd_word <= {1'b0, echo, slv_rdata};
            end
        end
    end

    // R6: the writes a pending read waits for are still in the queue
    p_ahead_in_fifo_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_busy |-> (ahead <= fcount));
    // R6: busy only drops at the end of a read transfer
    p_busy_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_busy) |-> ($past(state) == ST_READ));
    // R4: a write transfer is not cut short
    p_write_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_WRITE) && !xfer_last) |=> (state == ST_WRITE));
    // R9: a rejected write never grows the queue
    p_reject_no_queue_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_ok) |=> (fcount <= $past(fcount)));
endmodule

// File: tb/tb_pmic_bridge.sv
module tb_pmic_bridge;
    localparam int DEPTH = 4;
    localparam int XC    = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode_sel = 2'd0;
    logic        rev_new = 1'b0;
    logic        wr_req = 1'b0;
    logic [17:0] wr_off = '0;
    logic [15:0] wr_data = '0;
    logic        rd_req = 1'b0;
    logic [17:0] rd_off = '0;
    logic        fifo_full, fifo_empty, rd_busy, err;
    logic [31:0] rd_word;

    always #10 clk = ~clk;

    pmic_bridge #(.FIFO_DEPTH(DEPTH), .XFER_CYC(XC)) dut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .rev_new(rev_new),
        .wr_req(wr_req), .wr_off(wr_off), .wr_data(wr_data),
        .rd_req(rd_req), .rd_off(rd_off),
        .fifo_full(fifo_full), .fifo_empty(fifo_empty), .rd_busy(rd_busy),
        .rd_word(rd_word), .err(err));

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference ----------------
    logic [21:0] q [$];
    int          m_regs [3][16];
    int          m_phase, m_cnt, m_ahead, m_rsid, m_ridx;
    bit          m_busy, m_err;
    logic [14:0] m_echo;
    logic [31:0] m_word;
    logic [21:0] m_cur;
    int          t_pre, t_wsid, t_rsid;
    bit          t_pop, t_start, t_push, t_acc;

    function automatic int slave_of(logic [17:0] off, logic [1:0] m);
        case (m)
            2'd0: return (off < 18'h01000) ? 0 : -1;
            2'd1: return (off < 18'h04000 && off[13:12] != 2'd3) ? int'(off[13:12]) : -1;
            2'd2: return (off < 18'h20000 && off[16:15] != 2'd3) ? int'(off[16:15]) : -1;
            default: return -1;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete();
            foreach (m_regs[i, j]) m_regs[i][j] = 0;
            m_phase = 0; m_cnt = 0; m_ahead = 0; m_busy = 0; m_err = 0;
            m_word = '0; m_echo = '0; m_rsid = 0; m_ridx = 0; m_cur = '0;
        end else begin
            t_pre   = q.size();
            t_wsid  = slave_of(wr_off, mode_sel);
            t_rsid  = slave_of(rd_off, mode_sel);
            t_start = (m_phase == 0) && m_busy && (m_ahead == 0);
            t_pop   = (m_phase == 0) && !t_start && (t_pre > 0);
            t_push  = wr_req && (t_wsid >= 0) && (t_pre < DEPTH);
            t_acc   = rd_req && !m_busy && (t_rsid >= 0);
            m_err   = (wr_req && t_wsid < 0) || (rd_req && !m_busy && t_rsid < 0);
            if (m_phase != 0) begin
                if (m_cnt == XC - 1) begin
                    if (m_phase == 1)
                        m_regs[m_cur[21:20]][m_cur[19:16]] = int'(m_cur[15:0]);
                    else begin
                        m_word = {1'b0, m_echo, 16'(m_regs[m_rsid][m_ridx])};
                        m_busy = 0;
                    end
                    m_phase = 0;
                end else m_cnt++;
            end else if (t_start) begin
                m_phase = 2; m_cnt = 0;
            end else if (t_pop) begin
                m_cur = q.pop_front();
                m_phase = 1; m_cnt = 0;
                if (m_busy) m_ahead--;
            end
            if (t_push) q.push_back({2'(t_wsid), wr_off[5:2], wr_data});
            if (t_acc) begin
                m_busy  = 1;
                m_ahead = t_pre + int'(t_push) - int'(t_pop);
                m_echo  = rev_new ? rd_off[16:2] : rd_off[14:0];
                m_rsid  = t_rsid;
                m_ridx  = int'(rd_off[5:2]);
            end
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2", "fifo_empty", 32'(fifo_empty), 32'(q.size() == 0));
            chk("R2", "fifo_full", 32'(fifo_full), 32'(q.size() == DEPTH));
            chk("R5", "rd_busy", 32'(rd_busy), 32'(m_busy));
            chk("R7", "rd_word", rd_word, m_word);
            chk("R9", "err", 32'(err), 32'(m_err));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic step();
        @(negedge clk);
    endtask

    task automatic quiet();
        wr_req = 1'b0;
        rd_req = 1'b0;
    endtask

    task automatic put_wr(logic [17:0] off, logic [15:0] d);
        wr_req = 1'b1; wr_off = off; wr_data = d;
    endtask

    task automatic put_rd(logic [17:0] off);
        rd_req = 1'b1; rd_off = off;
    endtask

    task automatic settle();
        repeat ((DEPTH + 2) * (XC + 1) + 4) step();
    endtask

    task automatic do_read(logic [17:0] off, string req, logic [31:0] exp);
        put_rd(off); step(); quiet();
        chk("R5", "busy after command", 32'(rd_busy), 32'd1);
        while (rd_busy) step();
        chk(req, "read word", rd_word, exp);
    endtask

    task automatic expect_err(string req);
        step(); quiet();
        chk(req, "err pulse", 32'(err), 32'd1);
        chk(req, "no read started", 32'(rd_busy), 32'd0);
        step();
        chk(req, "err one cycle", 32'(err), 32'd0);
    endtask

    initial begin
        // R1: reset state
        repeat (3) step();
        chk("R1", "empty", 32'(fifo_empty), 32'd1);
        chk("R1", "full", 32'(fifo_full), 32'd0);
        chk("R1", "busy", 32'(rd_busy), 32'd0);
        chk("R1", "word", rd_word, 32'd0);
        chk("R1", "err", 32'(err), 32'd0);
        rst_n = 1'b1;
        step();
        do_read(18'h00C, "R1", 32'h000C0000);

        // R4 R7: two writes in order, read back, 10-bit mode, older echo
        put_wr(18'h004, 16'hA5A5); step();
        put_wr(18'h008, 16'h0F0F); step(); quiet();
        chk("R2", "queue holds second write", 32'(fifo_empty), 32'd0);
        settle();
        do_read(18'h004, "R7", 32'h0004A5A5);
        do_read(18'h008, "R4", 32'h00080F0F);

        // R2 R3: saturate the queue, sixth write dropped
        for (int k = 0; k < 6; k++) begin
            put_wr(18'(18'h024 + 4 * k), 16'(16'h1000 + k)); step();
            if (k == 4) chk("R2", "full after burst", 32'(fifo_full), 32'd1);
        end
        quiet(); settle();
        do_read(18'h038, "R3", 32'h00380000);
        do_read(18'h034, "R4", 32'h00341004);

        // R6: read shares its cycle with a write to the same register
        put_wr(18'h010, 16'h5555); step();
        put_wr(18'h008, 16'h1234); put_rd(18'h008); step(); quiet();
        while (rd_busy) step();
        chk("R6", "read after queued writes", rd_word, 32'h00081234);

        // R5: second command while busy is ignored
        put_rd(18'h004); step(); put_rd(18'h008); step(); quiet();
        while (rd_busy) step();
        chk("R5", "ignored second read", rd_word, 32'h0004A5A5);
        settle();

        // R8 R10: 12-bit mode, three slaves
        mode_sel = 2'd1;
        put_wr(18'h01004, 16'h1111); step();
        put_wr(18'h02004, 16'h2222); step();
        put_wr(18'h00004, 16'h3333); step(); quiet();
        settle();
        do_read(18'h01004, "R8", 32'h10041111);
        do_read(18'h02004, "R10", 32'h20042222);
        do_read(18'h00004, "R10", 32'h00043333);
        put_wr(18'h03004, 16'hDEAD); expect_err("R9");
        put_rd(18'h04000); expect_err("R9");
        settle();
        do_read(18'h01044, "R10", 32'h10441111);

        // R7 R8: 15-bit mode, newer echo
        mode_sel = 2'd2; rev_new = 1'b1;
        put_wr(18'h08010, 16'hBEEF); step(); quiet();
        settle();
        do_read(18'h08010, "R7", 32'h2004BEEF);
        rev_new = 1'b0;
        do_read(18'h08010, "R7", 32'h0010BEEF);
        put_rd(18'h20000); expect_err("R9");
        put_rd(18'h18000); expect_err("R9");

        // R8: reserved mode rejects everything
        mode_sel = 2'd3;
        put_wr(18'h00004, 16'h7777); expect_err("R8");
        put_rd(18'h00004); expect_err("R8");
        settle();

        // R9 boundary in 10-bit mode
        mode_sel = 2'd0;
        put_wr(18'h01000, 16'h9999); expect_err("R9");
        put_wr(18'h00FFC, 16'h4242); step(); quiet();
        settle();
        do_read(18'h00FFC, "R8", 32'h0FFC4242);
        do_read(18'h00004, "R9", 32'h00043333);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule